// File: doc/BRIEF.md
# CPU Memory Port to Wishbone Bridge

This block sits between a processor's request/grant memory port and a pipelined Wishbone bus. It turns each processor access into a single-access Wishbone cycle. One instance serves one port, either instruction fetch or data. The bridge has two states, idle and busy. When it is idle and sees a request, it grants the request at once and registers the address, write enable, byte enables and write data. It then runs one bus cycle and withholds the grant until the slave answers.

The slave ends the cycle with an acknowledge or an error. In the next cycle the processor receives a one-cycle read-valid pulse with the captured read data and an error flag. Only one access is ever outstanding. A processor that keeps its request high is served strictly one access after another. The bus side carries a word address: the byte address with the byte-lane bits dropped.

Top module: `cpu_wb_bridge`

## Requirements
- R1: While reset is held and after its release with no request, `wb_cyc_o`, `wb_stb_o`, `cpu_rvalid` and `cpu_err` are low.
- R2: When the bridge is idle, `cpu_gnt` equals `cpu_req` in the same cycle.
- R3: In the cycle after a grant, `wb_cyc_o` and `wb_stb_o` are high. `wb_adr_o` equals `cpu_addr` shifted right by log2(bytes per word), which is 2 by default. `wb_sel_o`, `wb_we_o` and `wb_dat_o` equal the granted `cpu_be`, `cpu_we` and `cpu_wdata`.
- R4: `wb_cyc_o` stays high until the cycle in which `wb_ack_i` or `wb_err_i` is sampled high, and then drops. `cpu_gnt` is low in every cycle in which `wb_cyc_o` is high.
- R5: `wb_stb_o` stays high while `wb_stall_i` is high. It is low after the first cycle in which it is high with `wb_stall_i` low, so it is high for exactly (stall cycles + 1) cycles per access.
- R6: In the cycle after `wb_ack_i` is sampled, `cpu_rvalid` is high for one cycle with `cpu_err` low. `cpu_rdata` equals the `wb_dat_i` sampled with the acknowledge.
- R7: In the cycle after `wb_err_i` is sampled, `cpu_rvalid` and `cpu_err` are both high for one cycle.
- R8: `wb_adr_o`, `wb_sel_o`, `wb_we_o` and `wb_dat_o` hold their values for the whole bus cycle, even when the processor inputs change.
- R9: An acknowledge or error that arrives while `wb_cyc_o` is low is ignored. No `cpu_rvalid` follows it.
- R10: A request held high across an access is granted again in the cycle of the previous `cpu_rvalid`. The accesses run strictly one after another, with results in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor access request |
| cpu_gnt | output | 1 | Request accepted this cycle |
| cpu_we | input | 1 | Write when high, read when low |
| cpu_be | input | DATA_W/8 | Byte enables |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rvalid | output | 1 | Response valid, one cycle |
| cpu_rdata | output | DATA_W | Read data |
| cpu_err | output | 1 | Response is a bus error |
| wb_cyc_o | output | 1 | Bus cycle active |
| wb_stb_o | output | 1 | Bus strobe |
| wb_we_o | output | 1 | Bus write enable |
| wb_sel_o | output | DATA_W/8 | Bus byte selects |
| wb_adr_o | output | ADDR_W-log2(DATA_W/8) | Bus word address |
| wb_dat_o | output | DATA_W | Bus write data |
| wb_dat_i | input | DATA_W | Bus read data |
| wb_ack_i | input | 1 | Bus acknowledge |
| wb_err_i | input | 1 | Bus error |
| wb_stall_i | input | 1 | Bus stall |

## Verification
The grant is due in the request cycle itself. The bus cycle with its fields is due one cycle after the grant. The strobe lasts stall + 1 cycles. The response is due exactly one cycle after the slave's acknowledge or error.

The bench drives inputs on the falling edge and samples on the falling edge. The grant is read just after the request is raised. The bus fields are read at the first falling edge after the accepting edge. A scoreboard pops each response when `cpu_rvalid` is seen and compares it with the expected data, error flag and strobe-cycle count. The bench slave acknowledges one cycle after it accepts the strobe, which fixes where each result must appear.

// File: rtl/cwb_pkg.sv
// Shared types for the CPU-to-Wishbone bridge.
package cwb_pkg;
    // Bridge control state: waiting for a request, or one bus access in flight.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } cwb_state_e;
endpackage

// File: rtl/cwb_fsm.sv
// Control state machine of the bridge.
// Grants a request only when idle, keeps the cycle open until ack/err,
// and holds the strobe until the slave has taken it (stall low).
// Assumes the slave ends every cycle with exactly one ack or err.
module cwb_fsm
    import cwb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic bus_ack,
    input  logic bus_err,
    input  logic bus_stall,
    output logic accept,
    output logic done,
    output logic busy,
    output logic stb
);
    cwb_state_e state_q;
    logic       stb_q;

    // Accept a request only in idle; finish on any slave answer while busy.
    always_comb begin
        accept = (state_q == ST_IDLE) && req;
        done   = (state_q == ST_BUSY) && (bus_ack || bus_err);
        busy   = (state_q == ST_BUSY);
        stb    = stb_q;
    end

    // State register: idle -> busy on accept, busy -> idle on answer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (accept) begin
            state_q <= ST_BUSY;
        end else if (done) begin
            state_q <= ST_IDLE;
        end
    end

    // Strobe: set on accept, cleared once the slave takes it or the cycle ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q <= 1'b0;
        end else if (accept) begin
            stb_q <= 1'b1;
        end else if (done) begin
            stb_q <= 1'b0;
        end else if (stb_q && !bus_stall) begin
            stb_q <= 1'b0;
        end
    end
endmodule

// File: rtl/cwb_req_capture.sv
// Request capture register.
// Stores the request fields on accept and holds them for the bus cycle.
// The byte-lane address bits are dropped to form a word address.
module cwb_req_capture #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SEL_W  = DATA_W / 8,
    parameter int OFF    = (SEL_W > 1) ? $clog2(SEL_W) : 0,
    parameter int WADR_W = ADDR_W - OFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              we_in,
    input  logic [SEL_W-1:0]  be_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    output logic              we_q,
    output logic [SEL_W-1:0]  sel_q,
    output logic [WADR_W-1:0] adr_q,
    output logic [DATA_W-1:0] dat_q
);
    logic [WADR_W-1:0] word_addr;

    // Word address: drop byte-lane bits when words are wider than a byte.
    generate
        if (OFF > 0) begin : g_word
            logic unused_lane;
            assign word_addr   = addr_in[ADDR_W-1:OFF];
            assign unused_lane = ^addr_in[OFF-1:0];
        end else begin : g_byte
            assign word_addr = addr_in;
        end
    endgenerate

    // Field registers: load only when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q  <= 1'b0;
            sel_q <= '0;
            adr_q <= '0;
            dat_q <= '0;
        end else if (accept) begin
            we_q  <= we_in;
            sel_q <= be_in;
            adr_q <= word_addr;
            dat_q <= wdata_in;
        end
    end
endmodule

// File: rtl/cwb_resp.sv
// Response stage.
// Turns the slave's ack/err into a one-cycle response pulse with
// registered read data and error flag for the processor.
module cwb_resp #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic              bus_err,
    input  logic [DATA_W-1:0] bus_dat,
    output logic              rvalid,
    output logic              err,
    output logic [DATA_W-1:0] rdata
);
    // Pulse generation: valid and error flag for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            err    <= 1'b0;
        end else begin
            rvalid <= done;
            err    <= done && bus_err;
        end
    end

    // Read data capture: sample the bus data with the answer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (done) begin
            rdata <= bus_dat;
        end
    end
endmodule

// File: rtl/cpu_wb_bridge.sv
// CPU memory port to pipelined Wishbone bridge, single outstanding access.
// Grant is combinational in idle and withheld while a bus cycle runs.
// Assumes a slave that answers each strobe with one ack or err.
module cpu_wb_bridge #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int SEL_W  = DATA_W / 8,
    localparam int OFF    = (SEL_W > 1) ? $clog2(SEL_W) : 0,
    localparam int WADR_W = ADDR_W - OFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    output logic              cpu_gnt,
    input  logic              cpu_we,
    input  logic [SEL_W-1:0]  cpu_be,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_rvalid,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_err,
    output logic              wb_cyc_o,
    output logic              wb_stb_o,
    output logic              wb_we_o,
    output logic [SEL_W-1:0]  wb_sel_o,
    output logic [WADR_W-1:0] wb_adr_o,
    output logic [DATA_W-1:0] wb_dat_o,
    input  logic [DATA_W-1:0] wb_dat_i,
    input  logic              wb_ack_i,
    input  logic              wb_err_i,
    input  logic              wb_stall_i
);
    logic accept;
    logic done;
    logic busy;

    cwb_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (cpu_req),
        .bus_ack   (wb_ack_i),
        .bus_err   (wb_err_i),
        .bus_stall (wb_stall_i),
        .accept    (accept),
        .done      (done),
        .busy      (busy),
        .stb       (wb_stb_o)
    );

    cwb_req_capture #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SEL_W  (SEL_W),
        .OFF    (OFF),
        .WADR_W (WADR_W)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .we_in    (cpu_we),
        .be_in    (cpu_be),
        .addr_in  (cpu_addr),
        .wdata_in (cpu_wdata),
        .we_q     (wb_we_o),
        .sel_q    (wb_sel_o),
        .adr_q    (wb_adr_o),
        .dat_q    (wb_dat_o)
    );

    cwb_resp #(
        .DATA_W (DATA_W)
    ) u_resp (
        .clk     (clk),
        .rst_n   (rst_n),
        .done    (done),
        .bus_err (wb_err_i),
        .bus_dat (wb_dat_i),
        .rvalid  (cpu_rvalid),
        .err     (cpu_err),
        .rdata   (cpu_rdata)
    );

    // Port mapping: grant mirrors acceptance, cycle mirrors the busy state.
    always_comb begin
        cpu_gnt  = accept;
        wb_cyc_o = busy;
    end
endmodule

// File: rtl/cwb_checker.sv
// Protocol checker for cpu_wb_bridge, attached by bind below.
module cwb_checker #(
    parameter int WADR_W = 30,
    parameter int DATA_W = 32,
    parameter int SEL_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              gnt,
    input logic              cyc,
    input logic              stb,
    input logic              stall,
    input logic              ack,
    input logic              berr,
    input logic              rvalid,
    input logic              cerr,
    input logic              we,
    input logic [SEL_W-1:0]  sel,
    input logic [WADR_W-1:0] adr,
    input logic [DATA_W-1:0] dat
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !cyc && !stb && !rvalid);

    assert_grant_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc && req) |-> gnt);

    assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        gnt |=> cyc && stb);

    assert_no_grant_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cyc |-> !gnt);

    assert_cyc_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc && !ack && !berr) |=> cyc);

    assert_cyc_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc && (ack || berr)) |=> (!cyc && rvalid));

    assert_stb_in_cyc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stb |-> cyc);

    assert_stb_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && stall && !ack && !berr) |=> stb);

    assert_stb_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !stall) |=> !stb);

    assert_rvalid_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(cyc && (ack || berr)));

    assert_rvalid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);

    assert_err_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cerr |-> rvalid);

    assert_fields_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc && $past(cyc)) |-> ($stable(adr) && $stable(sel) && $stable(we) && $stable(dat)));

    assert_stray_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc && (ack || berr)) |=> !rvalid);
endmodule

bind cpu_wb_bridge cwb_checker #(
    .WADR_W (WADR_W),
    .DATA_W (DATA_W),
    .SEL_W  (SEL_W)
) u_cwb_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (cpu_req),
    .gnt    (cpu_gnt),
    .cyc    (wb_cyc_o),
    .stb    (wb_stb_o),
    .stall  (wb_stall_i),
    .ack    (wb_ack_i),
    .berr   (wb_err_i),
    .rvalid (cpu_rvalid),
    .cerr   (cpu_err),
    .we     (wb_we_o),
    .sel    (wb_sel_o),
    .adr    (wb_adr_o),
    .dat    (wb_dat_o)
);

// File: tb/tb_cpu_wb_bridge.sv
module tb_cpu_wb_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_gnt;
    logic        cpu_we = 1'b0;
    logic [3:0]  cpu_be = 4'h0;
    logic [31:0] cpu_addr = 32'h0;
    logic [31:0] cpu_wdata = 32'h0;
    logic        cpu_rvalid;
    logic [31:0] cpu_rdata;
    logic        cpu_err;
    logic        wb_cyc_o, wb_stb_o, wb_we_o;
    logic [3:0]  wb_sel_o;
    logic [29:0] wb_adr_o;
    logic [31:0] wb_dat_o;
    logic [31:0] s_dat = 32'h0;
    logic        s_ack = 1'b0, s_err = 1'b0, stray = 1'b0;
    logic        wb_ack_i, wb_err_i, wb_stall_i;
    logic [3:0]  scnt = 4'h0;
    int          cfg_stall = 0;
    logic        cfg_err = 1'b0;

    int tests = 0;
    int fails = 0;
    int cyc_count = 0;
    int stb_seen = 0;

    logic [31:0] smem [16];
    logic [31:0] rmem [16];

    logic [29:0] exp_adr;
    logic [3:0]  exp_sel;
    logic        exp_we;
    logic [31:0] exp_dat;

    typedef struct packed {
        logic [31:0] d;
        logic        e;
        logic [7:0]  n;
    } resp_t;
    resp_t sb[$];

    always #10 clk = ~clk;

    cpu_wb_bridge dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_gnt(cpu_gnt),
        .cpu_we(cpu_we), .cpu_be(cpu_be), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .cpu_err(cpu_err),
        .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o), .wb_we_o(wb_we_o), .wb_sel_o(wb_sel_o),
        .wb_adr_o(wb_adr_o), .wb_dat_o(wb_dat_o), .wb_dat_i(s_dat),
        .wb_ack_i(wb_ack_i), .wb_err_i(wb_err_i), .wb_stall_i(wb_stall_i)
    );

    assign wb_ack_i   = s_ack | stray;
    assign wb_err_i   = s_err;
    assign wb_stall_i = wb_cyc_o && (scnt != 4'h0);

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Bench slave: stall for cfg_stall strobe cycles, then answer one cycle later.
    always @(posedge clk) begin
        s_ack <= 1'b0;
        s_err <= 1'b0;
        if (!wb_cyc_o) begin
            scnt <= cfg_stall[3:0];
        end else if (wb_stb_o) begin
            if (scnt != 4'h0) begin
                scnt <= scnt - 4'h1;
            end else if (cfg_err) begin
                s_err <= 1'b1;
                s_dat <= 32'h0;
            end else begin
                s_ack <= 1'b1;
                if (wb_we_o) begin
                    for (int b = 0; b < 4; b++)
                        if (wb_sel_o[b]) smem[wb_adr_o[3:0]][8*b +: 8] <= wb_dat_o[8*b +: 8];
                    s_dat <= 32'h0;
                end else begin
                    s_dat <= smem[wb_adr_o[3:0]];
                end
            end
        end
    end

    // Monitor: bus rules during a cycle, scoreboard compare on each response.
    always @(negedge clk) begin
        if (rst_n) begin
            if (wb_cyc_o) begin
                check(!cpu_gnt, "R4 grant low while busy", {31'h0, cpu_gnt}, 32'h0);
                check(wb_adr_o == exp_adr && wb_sel_o == exp_sel && wb_we_o == exp_we
                      && wb_dat_o == exp_dat, "R8 bus fields held", {2'b0, wb_adr_o}, {2'b0, exp_adr});
                if (wb_stb_o) stb_seen++;
            end
            if (cpu_rvalid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R10 unexpected response", 32'h1, 32'h0);
                end else begin
                    resp_t x;
                    x = sb.pop_front();
                    check(cpu_err == x.e, x.e ? "R7 error flag" : "R6 error flag low", {31'h0, cpu_err}, {31'h0, x.e});
                    if (!x.e) check(cpu_rdata == x.d, "R6 read data", cpu_rdata, x.d);
                    check(stb_seen == int'(x.n), "R5 strobe cycles", stb_seen, {24'h0, x.n});
                end
                stb_seen = 0;
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc_count++;
        if (cyc_count == 20000) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic set_expect(input logic w, input logic [3:0] idx, input logic [3:0] be,
                              input logic [31:0] wd, input logic e, input int st);
        resp_t x;
        exp_adr = {26'h0, idx};
        exp_sel = be;
        exp_we  = w;
        exp_dat = wd;
        x.n = st[7:0] + 8'd1;
        x.e = e;
        x.d = 32'h0;
        if (!e) begin
            if (w) begin
                for (int b = 0; b < 4; b++)
                    if (be[b]) rmem[idx][8*b +: 8] = wd[8*b +: 8];
            end else begin
                x.d = rmem[idx];
            end
        end
        sb.push_back(x);
    endtask

    task automatic drive(input logic w, input logic [3:0] idx, input logic [3:0] be, input logic [31:0] wd);
        cpu_req   = 1'b1;
        cpu_we    = w;
        cpu_be    = be;
        cpu_addr  = {26'h0, idx, 2'b01};
        cpu_wdata = wd;
    endtask

    // One access: grant now, bus fields one cycle later, scramble inputs, wait response.
    task automatic access(input logic w, input logic [3:0] idx, input logic [3:0] be,
                          input logic [31:0] wd, input logic e, input int st);
        cfg_stall = st;
        cfg_err   = e;
        set_expect(w, idx, be, wd, e, st);
        drive(w, idx, be, wd);
        #1;
        check(cpu_gnt, "R2 grant same cycle", {31'h0, cpu_gnt}, 32'h1);
        @(negedge clk);
        check(wb_cyc_o && wb_stb_o, "R3 cycle and strobe start", {30'h0, wb_cyc_o, wb_stb_o}, 32'h3);
        check(wb_adr_o == exp_adr, "R3 word address", {2'b0, wb_adr_o}, {2'b0, exp_adr});
        check(wb_sel_o == be && wb_we_o == w && wb_dat_o == wd, "R3 sel/we/data",
              wb_dat_o, wd);
        cpu_req   = 1'b0;
        cpu_addr  = ~cpu_addr;
        cpu_wdata = ~cpu_wdata;
        cpu_be    = ~cpu_be;
        cpu_we    = ~cpu_we;
        while (!cpu_rvalid) @(negedge clk);
    endtask

    // Two accesses with the request held high throughout.
    task automatic back_to_back(input logic [3:0] ia, input logic [3:0] ib, input int st);
        cfg_stall = st;
        cfg_err   = 1'b0;
        set_expect(1'b0, ia, 4'hF, 32'h0, 1'b0, st);
        drive(1'b0, ia, 4'hF, 32'h0);
        @(negedge clk);
        drive(1'b1, ib, 4'h3, 32'hA5A5_1234);
        while (!cpu_rvalid) @(negedge clk);
        set_expect(1'b1, ib, 4'h3, 32'hA5A5_1234, 1'b0, st);
        check(cpu_gnt, "R10 regrant in response cycle", {31'h0, cpu_gnt}, 32'h1);
        @(negedge clk);
        check(wb_cyc_o && wb_adr_o == {26'h0, ib}, "R10 second access started",
              {2'b0, wb_adr_o}, {28'h0, ib});
        cpu_req = 1'b0;
        while (!cpu_rvalid) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            smem[i] = 32'h1000_0000 + i * 32'h0101_0101;
            rmem[i] = 32'h1000_0000 + i * 32'h0101_0101;
        end
        exp_adr = '0; exp_sel = '0; exp_we = 1'b0; exp_dat = '0;
        repeat (3) @(negedge clk);
        check(!wb_cyc_o && !wb_stb_o && !cpu_rvalid && !cpu_err, "R1 quiet in reset",
              {28'h0, wb_cyc_o, wb_stb_o, cpu_rvalid, cpu_err}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!wb_cyc_o && !wb_stb_o && !cpu_rvalid && !cpu_err, "R1 quiet after reset",
              {28'h0, wb_cyc_o, wb_stb_o, cpu_rvalid, cpu_err}, 32'h0);

        access(1'b0, 4'd4, 4'hF, 32'h0, 1'b0, 0);          // R6 plain read
        access(1'b1, 4'd5, 4'b0101, 32'hCAFE_BEEF, 1'b0, 2); // R5 write with stalls
        access(1'b0, 4'd5, 4'hF, 32'h0, 1'b0, 1);          // R6 merged bytes
        access(1'b0, 4'd7, 4'hF, 32'h0, 1'b1, 0);          // R7 bus error
        access(1'b0, 4'd7, 4'hF, 32'h0, 1'b0, 3);          // R6 normal after error

        // R9: stray acknowledge while idle
        @(negedge clk);
        stray = 1'b1;
        @(negedge clk);
        stray = 1'b0;
        for (int k = 0; k < 3; k++) begin
            check(!cpu_rvalid && !wb_cyc_o, "R9 stray ack ignored", {31'h0, cpu_rvalid}, 32'h0);
            @(negedge clk);
        end

        back_to_back(4'd2, 4'd9, 0);                        // R10
        back_to_back(4'd9, 4'd3, 2);                        // R10 with stalls
        access(1'b0, 4'd9, 4'hF, 32'h0, 1'b0, 0);           // R10 ordered write visible

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R10 all responses seen", sb.size(), 32'h0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule